// File: doc/BRIEF.md
# USB Endpoint Interrupt Flag Controller

This block keeps the completion flags that a small USB device function reports to its CPU. The flags cover transmit and receive done on the control endpoint, transmit done on a buffer that two data endpoints share, end of packet, and resume. The serial interface engine raises each flag with a one-cycle strobe. Software clears a flag by writing 1 to the clear bit at that flag's position, and it chooses which flags raise the single interrupt line.

The block also holds the suspend control bit. That bit drives a clock-stop output toward the USB logic. The shared transmit flag takes part in the handshake directly. When the engine presents an IN token for endpoint 1 or 2, the block answers one cycle later with either "send data" (ACK path) or NAK. It decides from the shared flag and from that endpoint's transmit-enable bit.

Top module: `usbf_flag_ctrl`

## Requirements
- R1: After a synchronous reset, all flags, enables, suspend and transmit enables are 0. The outputs irq, usb_clk_stop, in_rsp_vld and in_rsp_ack are 0, and every register reads 0.
- R2: An event strobe sets its flag on the next clock edge. Register 0 shows the control transmit flag at bit 7 and the control receive flag at bit 6. Register 1 shows the shared transmit flag at bit 7, end-of-packet at bit 6 and resume at bit 5.
- R3: Writing 1 to a flag's bit position in its register clears that flag. Writing 0 there leaves the flag unchanged. Writes cannot set a flag.
- R4: If an event strobe and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: irq is the registered OR of every flag ANDed with its enable, and it follows the flags one cycle later. The enables are register 0 bit 3 (control transmit), register 0 bit 2 (control receive), register 1 bit 3 (shared transmit) and register 1 bit 2 (end of packet). The resume flag always counts toward irq.
- R6: Only the ACK-received strobe for the shared buffer sets the shared transmit flag.
- R7: While the shared transmit flag is set, an IN token for endpoint 1 or 2 gets in_rsp_vld=1 with in_rsp_ack=0 (NAK) one cycle later.
- R8: While the shared flag is clear, an IN token for endpoint 1 or 2 gets in_rsp_ack=1 only if that endpoint's transmit enable is set. Endpoint 1's enable is register 2 bit 0 and endpoint 2's is register 2 bit 1. Tokens for endpoints 0 and 3 produce no response.
- R9: Register 0 bit 0 is the read/write suspend bit and drives usb_clk_stop. Writing 0 there releases it.
- R10: The resume strobe sets the resume flag while suspend is asserted.
- R11: The reserved bits read 0: register 0 bits 5, 4 and 1, register 1 bits 4, 1 and 0, and register 2 bits 7 to 2. Address 3 reads 0. Read data appears one cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| ev_ctl_tx | input | 1 | Control endpoint transmit done strobe |
| ev_ctl_rx | input | 1 | Control endpoint receive done strobe |
| ev_shr_ack | input | 1 | Shared buffer sent and ACK received strobe |
| ev_eop | input | 1 | End-of-packet strobe |
| ev_resume | input | 1 | Resume detected strobe |
| in_tok | input | 1 | IN token seen |
| in_ep | input | 2 | Endpoint number of the IN token |
| in_rsp_vld | output | 1 | Handshake decision valid |
| in_rsp_ack | output | 1 | 1 = send data, 0 = NAK |
| irq | output | 1 | Combined interrupt request |
| usb_clk_stop | output | 1 | Clock stop toward USB logic |

## Verification
A completion strobe from the engine can arrive in the same cycle as a software write that clears the same flag. The bench provokes this by raising the shared-buffer ACK strobe and the clearing write to register 1 on one clock edge. It passes only if the later read shows the flag still set and the next IN token is answered with NAK. A second collision puts an IN token in the same cycle as the ACK strobe. The decision must use the flag value from before that edge.

// File: rtl/usbf_flag_pkg.sv
package usbf_flag_pkg;
  localparam int DW    = 8;
  localparam int NFLAG = 5;
  // flag indices
  localparam int F_CTX = 0;
  localparam int F_CRX = 1;
  localparam int F_STX = 2;
  localparam int F_EOP = 3;
  localparam int F_RSM = 4;
  // register addresses
  localparam int REG_CTL = 0;
  localparam int REG_SHR = 1;
  localparam int REG_TXE = 2;
  typedef logic [DW-1:0]    byte_t;
  typedef logic [NFLAG-1:0] flagv_t;
endpackage

// File: rtl/usbf_flag_cell.sv
module usbf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/usbf_in_decide.sv
module usbf_in_decide #(
  parameter int NEP_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok,
  input  logic [NEP_W-1:0] ep,
  input  logic             shr_busy,
  input  logic [1:0]       tx_en,
  output logic             vld,
  output logic             ack
);
  logic is_ep1, is_ep2, ep_en;
  always_comb begin
    is_ep1 = (ep == NEP_W'(1));
    is_ep2 = (ep == NEP_W'(2));
    ep_en  = (is_ep1 & tx_en[0]) | (is_ep2 & tx_en[1]);
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      ack <= 1'b0;
    end else begin
      vld <= tok & (is_ep1 | is_ep2);
      ack <= tok & ep_en & ~shr_busy;
    end
  end
endmodule

// File: rtl/usbf_flag_ctrl.sv
module usbf_flag_ctrl
  import usbf_flag_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              ev_ctl_tx,
  input  logic              ev_ctl_rx,
  input  logic              ev_shr_ack,
  input  logic              ev_eop,
  input  logic              ev_resume,
  input  logic              in_tok,
  input  logic [1:0]        in_ep,
  output logic              in_rsp_vld,
  output logic              in_rsp_ack,
  output logic              irq,
  output logic              usb_clk_stop
);
  flagv_t evt_vec, clr_vec, flag_q, ie_q;
  logic   wr_ctl, wr_shr, wr_txe;
  logic   susp_q;
  logic [1:0] txe_q;
  byte_t  rd_mux;

  always_comb begin
    wr_ctl = bus_wr & (bus_addr == ADDR_W'(REG_CTL));
    wr_shr = bus_wr & (bus_addr == ADDR_W'(REG_SHR));
    wr_txe = bus_wr & (bus_addr == ADDR_W'(REG_TXE));
    evt_vec        = '0;
    evt_vec[F_CTX] = ev_ctl_tx;
    evt_vec[F_CRX] = ev_ctl_rx;
    evt_vec[F_STX] = ev_shr_ack;
    evt_vec[F_EOP] = ev_eop;
    evt_vec[F_RSM] = ev_resume;
    clr_vec        = '0;
    clr_vec[F_CTX] = wr_ctl & bus_wdata[7];
    clr_vec[F_CRX] = wr_ctl & bus_wdata[6];
    clr_vec[F_STX] = wr_shr & bus_wdata[7];
    clr_vec[F_EOP] = wr_shr & bus_wdata[6];
    clr_vec[F_RSM] = wr_shr & bus_wdata[5];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    usbf_flag_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .set_i(evt_vec[i]),
      .clr_i(clr_vec[i]),
      .q    (flag_q[i])
    );
  end

  // enables, suspend and endpoint transmit enables
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      susp_q <= 1'b0;
      txe_q  <= '0;
    end else begin
      if (wr_ctl) begin
        ie_q[F_CTX] <= bus_wdata[3];
        ie_q[F_CRX] <= bus_wdata[2];
        susp_q      <= bus_wdata[0];
      end
      if (wr_shr) begin
        ie_q[F_STX] <= bus_wdata[3];
        ie_q[F_EOP] <= bus_wdata[2];
      end
      if (wr_txe) txe_q <= bus_wdata[1:0];
      ie_q[F_RSM] <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_CTL): rd_mux = {flag_q[F_CTX], flag_q[F_CRX], 2'b00,
                                  ie_q[F_CTX], ie_q[F_CRX], 1'b0, susp_q};
      ADDR_W'(REG_SHR): rd_mux = {flag_q[F_STX], flag_q[F_EOP], flag_q[F_RSM], 1'b0,
                                  ie_q[F_STX], ie_q[F_EOP], 2'b00};
      ADDR_W'(REG_TXE): rd_mux = {6'b0, txe_q};
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |(flag_q & ie_q);
    end
  end

  assign usb_clk_stop = susp_q;

  usbf_in_decide #(.NEP_W(2)) u_in (
    .clk     (clk),
    .rst     (rst),
    .tok     (in_tok),
    .ep      (in_ep),
    .shr_busy(flag_q[F_STX]),
    .tx_en   (txe_q),
    .vld     (in_rsp_vld),
    .ack     (in_rsp_ack)
  );
endmodule

// File: rtl/usbf_flag_ctrl_chk.sv
module usbf_flag_ctrl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              in_tok,
  input logic [1:0]        in_ep,
  input logic              in_rsp_vld,
  input logic              in_rsp_ack,
  input logic              irq,
  input logic [4:0]        evt_vec,
  input logic [4:0]        flag_q,
  input logic [4:0]        ie_q
);
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (evt_vec != 5'd0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec))); // R4
  AST_CLEAR_SHARED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[7] && !evt_vec[2]) |=> !flag_q[2]); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(flag_q & ie_q)))); // R5
  AST_NAK_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_tok && (in_ep == 2'd1 || in_ep == 2'd2) && flag_q[2]) |=> (in_rsp_vld && !in_rsp_ack)); // R7
  AST_NO_RSP_OTHER_EP: assert property (@(posedge clk) disable iff (rst)
    (in_tok && (in_ep == 2'd0 || in_ep == 2'd3)) |=> !in_rsp_vld); // R8
  AST_ACK_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
    in_rsp_ack |-> in_rsp_vld); // R8
endmodule

bind usbf_flag_ctrl usbf_flag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .in_tok    (in_tok),
  .in_ep     (in_ep),
  .in_rsp_vld(in_rsp_vld),
  .in_rsp_ack(in_rsp_ack),
  .irq       (irq),
  .evt_vec   (evt_vec),
  .flag_q    (flag_q),
  .ie_q      (ie_q)
);

// File: tb/usbf_flag_ctrl_test.sv
`timescale 1ns/1ps
module usbf_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ev_ctl_tx = 0, ev_ctl_rx = 0, ev_shr_ack = 0, ev_eop = 0, ev_resume = 0;
  logic       in_tok = 0;
  logic [1:0] in_ep = '0;
  logic       in_rsp_vld, in_rsp_ack, irq, usb_clk_stop;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usbf_flag_ctrl #(.ADDR_W(2)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); bus_addr = 2'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic tok(input int ep, output int v, output int k);
    @(negedge clk); in_tok = 1; in_ep = 2'(ep);
    @(negedge clk); in_tok = 0; v = in_rsp_vld; k = in_rsp_ack;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic t_reset;
    int d;
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 clk_stop", usb_clk_stop, 0);
    check("R1 rsp_vld", in_rsp_vld, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, d); check("R1 reg", d, 0);
    end
  endtask

  task automatic t_ctl_flags;
    int d;
    do_reset();
    @(negedge clk); ev_ctl_tx = 1;
    @(negedge clk); ev_ctl_tx = 0;
    check("R5 irq masked", irq, 0);
    rd(0, d); check("R2 ctl tx flag", d, 8'h80);
    wr(0, 8'h08);
    @(negedge clk); check("R5 irq enabled", irq, 1);
    wr(0, 8'h08);  // bit 7 at 0: no clear
    rd(0, d); check("R3 write 0 keeps flag", d, 8'h88);
    wr(0, 8'h88);
    rd(0, d); check("R3 clear ctl tx", d, 8'h08);
    @(negedge clk); check("R5 irq drops", irq, 0);
    @(negedge clk); ev_ctl_rx = 1;
    @(negedge clk); ev_ctl_rx = 0;
    check("R5 irq lags flag", irq, 0);
    rd(0, d); check("R2 ctl rx flag", d, 8'h48);
    @(negedge clk); check("R5 rx masked", irq, 0);
    wr(0, 8'h04);
    @(negedge clk); check("R5 rx enabled", irq, 1);
    wr(0, 8'h44);
    rd(0, d); check("R3 clear ctl rx", d, 8'h04);
  endtask

  task automatic t_shared;
    int d, v, k;
    do_reset();
    wr(2, 8'h01);
    tok(1, v, k); check("R8 ep1 vld", v, 1); check("R8 ep1 ack", k, 1);
    tok(2, v, k); check("R8 ep2 disabled vld", v, 1); check("R8 ep2 disabled nak", k, 0);
    tok(0, v, k); check("R8 ep0 no rsp", v, 0);
    tok(3, v, k); check("R8 ep3 no rsp", v, 0);
    @(negedge clk); ev_ctl_tx = 1; ev_eop = 1; ev_ctl_rx = 1;
    @(negedge clk); ev_ctl_tx = 0; ev_eop = 0; ev_ctl_rx = 0;
    rd(1, d); check("R6 other events leave shared", d & 8'h80, 0);
    check("R2 eop flag", d, 8'h40);
    wr(2, 8'h03);
    // token in same cycle as ACK strobe: decided on old flag
    @(negedge clk); ev_shr_ack = 1; in_tok = 1; in_ep = 2'd2;
    @(negedge clk); ev_shr_ack = 0; in_tok = 0;
    check("R7 same-cycle uses old flag", in_rsp_ack, 1);
    tok(1, v, k); check("R7 busy vld", v, 1); check("R7 busy nak", k, 0);
    // set wins over clear
    @(negedge clk); ev_shr_ack = 1; bus_addr = 2'd1; bus_wdata = 8'h80; bus_wr = 1;
    @(negedge clk); ev_shr_ack = 0; bus_wr = 0;
    rd(1, d); check("R4 set beats clear", d & 8'h80, 8'h80);
    tok(2, v, k); check("R4 still nak", k, 0);
    wr(1, 8'h08);
    @(negedge clk); check("R5 shared irq", irq, 1);
    wr(1, 8'h88);
    rd(1, d); check("R3 shared cleared", d & 8'h80, 0);
    tok(2, v, k); check("R8 ack after clear", k, 1);
  endtask

  task automatic t_suspend;
    int d;
    do_reset();
    wr(0, 8'h01);
    check("R9 clk_stop on", usb_clk_stop, 1);
    @(negedge clk); ev_resume = 1;
    @(negedge clk); ev_resume = 0;
    rd(1, d); check("R10 resume while suspended", d, 8'h20);
    check("R5 resume irq", irq, 1);
    wr(0, 8'h00);
    check("R9 clk_stop off", usb_clk_stop, 0);
    wr(1, 8'h20);
    rd(1, d); check("R3 resume cleared", d, 0);
  endtask

  task automatic t_layout;
    int d;
    do_reset();
    wr(0, 8'hFF);
    rd(0, d); check("R11 reg0 reserved", d, 8'h0D);
    wr(1, 8'hFF);
    rd(1, d); check("R11 reg1 reserved", d, 8'h0C);
    wr(2, 8'hFF);
    rd(2, d); check("R11 reg2 reserved", d, 8'h03);
    wr(3, 8'hFF);
    rd(3, d); check("R11 addr3", d, 0);
  endtask

  initial begin
    t_reset();
    t_ctl_flags();
    t_shared();
    t_suspend();
    t_layout();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule